// File: doc/BRIEF.md
# Polled Byte Output Controller

This block sits between a host register bus and a byte-wide output device. The host sees three registers: a status word, a command word and an outgoing data byte. To send a character it polls the status word until the busy flag reads zero, loads the command and the byte, and then writes the status word with the command-ready flag set. The controller picks the command up, raises busy, checks the command code, and for a write it offers the byte on a valid/ready device port until the device accepts it.

When the work is done, the controller lowers its flags in a fixed order that the host can poll on. Command-ready drops first. The error flag drops next, and only after a good write. Busy drops last. An unknown command code raises the error flag and finishes without touching the device port. Host writes that arrive while the controller is busy are dropped and recorded in a sticky overrun flag. The host sends a whole string by repeating this poll, load and start sequence once per character.

Top module: `polled_byte_ctrl`

## Requirements
- R1: After reset the status word, the command register and the data register all read 0, and dev_valid is low.
- R2: Writing the command and data registers without setting command-ready starts nothing: busy and dev_valid stay low, and the two registers read back the written values (command at address 1, data at address 2).
- R3: A status write (address 0) with bit 1 set raises command-ready (status bit 1) at that clock edge. Busy (status bit 0) rises on the following edge and never rises without command-ready.
- R4: For command code 0x01 (write), dev_valid rises one edge after busy, with dev_data equal to the data register. dev_valid and dev_data hold until a clock edge with dev_ready high. Busy stays set for the whole wait.
- R5: After a write is accepted, command-ready clears at the accepting edge, the error flag (status bit 2) clears on the next edge, and busy clears on the edge after that.
- R6: Any other command code sets the error flag and clears command-ready one edge after busy rises. Busy clears on the next edge, dev_valid never rises, and the error flag stays set.
- R7: A host write to address 1 or 2 while busy is set does not change the register, and it sets the sticky overrun flag (status bit 3).
- R8: A status write with bit 3 set while the controller is not busy clears the overrun flag.
- R9: A host that repeats poll, load and start for each character delivers every byte of a string to the device in order, one transfer per good command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 command, 2 data |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| dev_data | output | 8 | Byte offered to the device |
| dev_valid | output | 1 | Byte on dev_data is valid |
| dev_ready | input | 1 | Device accepts the byte |

## Verification
The hardest case to reach is the retirement ordering seen against an error flag that is already set. Error only drops on the good-write path, so the bench first issues an unknown command to leave the flag set. It then runs a write and samples status on each of the three edges after the device handshake. The same write is held for several cycles with dev_ready low, and during that stall the bench writes to the command and data registers. This checks the overrun flag and confirms that the registers keep their values while a transfer is in flight.

// File: rtl/polled_byte_ctrl.sv
module polled_byte_ctrl #(
  parameter int DW = 8,
  parameter logic [DW-1:0] WRITE_CODE = 'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] dev_data,
  output logic          dev_valid,
  input  logic          dev_ready
);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_DECODE, S_SEND, S_DROP_ERR, S_DROP_BUSY} state_t;

  state_t        state;
  logic          busy, cmd_ready, err, overrun;
  logic [DW-1:0] cmd_q, data_q;

  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_reg  = bus_wr && (bus_addr == A_CMD || bus_addr == A_DATA);
  wire [DW-1:0] stat_word = DW'({overrun, err, cmd_ready, busy});

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = stat_word;
      A_CMD:   bus_rdata = cmd_q;
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = '0;
    endcase
  end

  assign dev_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      cmd_ready <= 1'b0;
      err       <= 1'b0;
      overrun   <= 1'b0;
      cmd_q     <= '0;
      data_q    <= '0;
      dev_valid <= 1'b0;
    end else begin
      if (busy) begin
        if (wr_reg) overrun <= 1'b1;
      end else begin
        if (bus_wr && bus_addr == A_CMD)  cmd_q  <= bus_wdata;
        if (bus_wr && bus_addr == A_DATA) data_q <= bus_wdata;
        if (wr_stat && bus_wdata[1]) cmd_ready <= 1'b1;
        if (wr_stat && bus_wdata[3]) overrun   <= 1'b0;
      end
      case (state)
        S_IDLE:
          if (cmd_ready) begin
            busy  <= 1'b1;
            state <= S_DECODE;
          end
        S_DECODE:
          if (cmd_q == WRITE_CODE) begin
            dev_valid <= 1'b1;
            state     <= S_SEND;
          end else begin
            err       <= 1'b1;
            cmd_ready <= 1'b0;
            state     <= S_DROP_BUSY;
          end
        S_SEND:
          if (dev_ready) begin
            dev_valid <= 1'b0;
            cmd_ready <= 1'b0;
            state     <= S_DROP_ERR;
          end
        S_DROP_ERR: begin
          err   <= 1'b0;
          state <= S_DROP_BUSY;
        end
        S_DROP_BUSY: begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_ready));

  p_valid_inside_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> busy);

  p_hold_until_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));

  p_ready_drops_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ready) |-> busy);

  p_busy_drops_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !cmd_ready && !dev_valid);

  p_bad_code_no_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> cmd_q == WRITE_CODE);

  p_locked_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_reg |=> overrun && $stable(cmd_q) && $stable(data_q));

endmodule

// File: tb/polled_byte_ctrl_tb.sv
`timescale 1ns/1ps
module polled_byte_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, dev_data;
  logic       dev_valid, dev_ready = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  polled_byte_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_data(dev_data),
    .dev_valid(dev_valid), .dev_ready(dev_ready));

  // {command, data, ready delay}
  localparam logic [23:0] VEC [7] = '{
    {8'h01, 8'h48, 8'd0}, {8'h01, 8'h65, 8'd3}, {8'h07, 8'h00, 8'd0},
    {8'h01, 8'h6C, 8'd1}, {8'h00, 8'h11, 8'd0}, {8'h01, 8'h6F, 8'd5},
    {8'h01, 8'h21, 8'd2}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic poll_idle();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      rd(0, s);
      if (!s[0]) return;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(0, s); chk("R1 status", s, 0);
    rd(1, r); chk("R1 cmd", r, 0);
    rd(2, r); chk("R1 data", r, 0);
    chk("R1 dev_valid", dev_valid, 0);

    // R2: load without start
    wr(1, 8'h07); wr(2, 8'hA5);
    repeat (5) @(negedge clk);
    rd(0, s); chk("R2 idle", s, 0);
    chk("R2 no valid", dev_valid, 0);
    rd(1, r); chk("R2 cmd readback", r, 8'h07);
    rd(2, r); chk("R2 data readback", r, 8'hA5);

    // R6: unknown code 0x07
    wr(0, 8'h02);
    rd(0, s); chk("R3 ready set, busy clear", s, 8'h02);
    @(negedge clk); rd(0, s); chk("R3 busy next edge", s, 8'h03);
    @(negedge clk); rd(0, s); chk("R6 error, ready cleared", s, 8'h05);
    chk("R6 no transfer", dev_valid, 0);
    @(negedge clk); rd(0, s); chk("R6 busy cleared, error kept", s, 8'h04);
    chk("R6 no transfer after", dev_valid, 0);

    // R4/R5/R7: good write with stalled device
    wr(1, 8'h01); wr(2, 8'h3C);
    wr(0, 8'h02);
    @(negedge clk); rd(0, s); chk("R3 busy", s, 8'h07);
    chk("R4 valid not yet", dev_valid, 0);
    @(negedge clk);
    chk("R4 valid", dev_valid, 1);
    chk("R4 data", dev_data, 8'h3C);
    wr(1, 8'h55); wr(2, 8'h66);
    repeat (2) @(negedge clk);
    chk("R4 valid held", dev_valid, 1);
    chk("R4 data held", dev_data, 8'h3C);
    rd(0, s); chk("R7 overrun while busy", s, 8'h0F);
    rd(1, r); chk("R7 cmd unchanged", r, 8'h01);
    rd(2, r); chk("R7 data unchanged", r, 8'h3C);
    dev_ready = 1;
    @(negedge clk); dev_ready = 0;
    rd(0, s); chk("R5 ready drops first", s, 8'h0D);
    chk("R5 valid dropped", dev_valid, 0);
    @(negedge clk); rd(0, s); chk("R5 error drops second", s, 8'h09);
    @(negedge clk); rd(0, s); chk("R5 busy drops last", s, 8'h08);
    wr(0, 8'h08);
    rd(0, s); chk("R8 overrun cleared", s, 8'h00);

    // R9: string by polling
    foreach (VEC[k]) begin
      logic [7:0] c, d, dl;
      int xfers, wait_n, busy_bad;
      bit seen_busy;
      {c, d, dl} = VEC[k];
      poll_idle();
      wr(1, c); wr(2, d); wr(0, 8'h02);
      xfers = 0; wait_n = 0; busy_bad = 0; seen_busy = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        dev_ready = 0;
        rd(0, s);
        if (s[0]) seen_busy = 1;
        if (dev_valid) begin
          if (!s[0]) busy_bad++;
          if (wait_n == int'(dl)) begin
            dev_ready = 1;
            xfers++;
            chk("R9 byte order", dev_data, d);
          end
          wait_n++;
        end
        if (seen_busy && !s[0]) break;
      end
      dev_ready = 0;
      chk("R9 transfer count", xfers, (c == 8'h01) ? 1 : 0);
      chk("R4 busy held during wait", busy_bad, 0);
      rd(0, s); chk("R9 final status", s, (c == 8'h01) ? 8'h00 : 8'h04);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule